// File: doc/BRIEF.md
# Constant-Operand Ripple Adder

This block adds a fixed value, chosen when the design is built, to a single variable operand. Because one input is known in advance, no full adders are needed. Each bit position reduces to a small two-input cell whose type depends on the corresponding bit of the constant.

Positions below the lowest set bit of the constant are plain wires to the output. From that position upward, a bit where the constant is 0 uses a half adder, which adds the incoming carry to the operand bit. A bit where the constant is 1 uses a modified half adder, which adds the incoming carry, the operand bit and one. The carry ripples upward and leaves the top stage as a carry-out.

An incrementer is the case where the constant is 1. A decrementer is the case where the constant is all ones. A constant of zero leaves only wires. The block has no clock and no state.

Top module: `const_adder`

## Requirements
- R1: `sum` equals (`opnd` + `ADDEND`) modulo 2^W for every operand value.
- R2: `carry_out` equals bit W of the (W+1)-bit value `opnd` + `ADDEND`.
- R3: Every `sum` bit below the lowest set bit of `ADDEND` equals the `opnd` bit at the same position.
- R4: With `ADDEND` = 1, `sum[0]` is the inverse of `opnd[0]`, and `carry_out` is 1 only when `opnd` is all ones.
- R5: With `ADDEND` all ones, `sum` equals `opnd` - 1 modulo 2^W, and `carry_out` is 1 exactly when `opnd` is nonzero.
- R6: With `ADDEND` = 0, `sum` equals `opnd` and `carry_out` is 0.
- R7: For a nonzero `ADDEND` with lowest set bit h, `sum[h]` is the inverse of `opnd[h]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | W | Variable operand |
| sum | output | W | Low W bits of opnd + ADDEND |
| carry_out | output | 1 | Carry out of the top stage |

## Verification
Four builds are swept over all 256 operand values at W = 8: a mixed constant (0x2C), 1, all ones and 0. The mixed constant uses both cell types, separated by runs of each. Its sweep shows whether a carry crosses half adders and modified half adders correctly, and whether the two low bits stay pure wires. The increment sweep and the decrement sweep each exercise a single cell type along the full chain, so a wrong cell equation shows up in one of them. Their all-ones and zero operands also produce the longest carry runs. The zero build confirms that the all-wire case gives no spurious carry.

// File: rtl/const_adder.sv
module const_adder #(
  parameter int W = 8,
  parameter logic [W-1:0] ADDEND = 8'h2C
) (
  input  logic [W-1:0] opnd,
  output logic [W-1:0] sum,
  output logic         carry_out
);

  function automatic int lowest_one(input logic [W-1:0] v);
    int pos;
    pos = W;
    for (int b = W - 1; b >= 0; b--)
      if (v[b]) pos = b;
    return pos;
  endfunction

  localparam int LOW = lowest_one(ADDEND);

  logic [W:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < LOW) begin : g_wire
      assign sum[i]  = opnd[i];
      assign cy[i+1] = cy[i];
    end else if (ADDEND[i]) begin : g_mha
      assign sum[i]  = ~(opnd[i] ^ cy[i]);
      assign cy[i+1] = opnd[i] | cy[i];
    end else begin : g_ha
      assign sum[i]  = opnd[i] ^ cy[i];
      assign cy[i+1] = opnd[i] & cy[i];
    end
  end

  assign carry_out = cy[W];

endmodule

// File: rtl/const_adder_chk.sv
module const_adder_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] ADDEND = 8'h2C
) (
  input logic [W-1:0] opnd,
  input logic [W-1:0] sum,
  input logic         carry_out
);

  localparam logic [W-1:0] LSB  = ADDEND & (~ADDEND + 1'b1);
  localparam logic [W-1:0] MASK = (LSB == '0) ? '1 : LSB - 1'b1;
  localparam logic [W:0]   WIDE = {1'b0, ADDEND};

  always_comb begin
    if (!$isunknown(opnd) && !$isunknown({carry_out, sum})) begin
      a_r1_sum_value: assert (sum == W'(({1'b0, opnd} + WIDE)))
        else $error("a_r1_sum_value");
      a_r2_carry_value: assert (carry_out == (({1'b0, opnd} + WIDE) >> W))
        else $error("a_r2_carry_value");
      a_r3_low_passthru: assert (((sum ^ opnd) & MASK) == '0)
        else $error("a_r3_low_passthru");
      if (LSB != '0) begin
        a_r7_lowest_flip: assert (((sum ^ opnd) & LSB) == LSB)
          else $error("a_r7_lowest_flip");
      end else begin
        a_r6_zero_const: assert (sum == opnd && !carry_out)
          else $error("a_r6_zero_const");
      end
    end
  end

endmodule

bind const_adder const_adder_chk #(.W(W), .ADDEND(ADDEND)) u_chk (
  .opnd(opnd),
  .sum(sum),
  .carry_out(carry_out)
);

// File: tb/tb_const_adder.sv
module tb_const_adder;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] x;
  logic [W-1:0] s_mix, s_inc, s_dec, s_zero;
  logic         c_mix, c_inc, c_dec, c_zero;

  const_adder #(.W(W), .ADDEND(8'h2C)) dut    (.opnd(x), .sum(s_mix),  .carry_out(c_mix));
  const_adder #(.W(W), .ADDEND(8'h01)) u_inc  (.opnd(x), .sum(s_inc),  .carry_out(c_inc));
  const_adder #(.W(W), .ADDEND(8'hFF)) u_dec  (.opnd(x), .sum(s_dec),  .carry_out(c_dec));
  const_adder #(.W(W), .ADDEND(8'h00)) u_zero (.opnd(x), .sum(s_zero), .carry_out(c_zero));

  int checks = 0;
  int failures = 0;

  task automatic chk(input string req, input int act, input int exp, input int xv);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s x=%0d actual=%0d expected=%0d", req, xv, act, exp);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    x = '0;
    for (int v = 0; v < 256; v++) begin
      @(posedge clk);
      x = W'(v);
      @(negedge clk);
      chk("R1", int'(s_mix), (v + 8'h2C) % 256, v);
      chk("R2", int'(c_mix), (v + 8'h2C) / 256, v);
      chk("R3", int'(s_mix[1:0]), v % 4, v);
      chk("R7", int'(s_mix[2]), ((v >> 2) & 1) ^ 1, v);
      chk("R1", int'(s_inc), (v + 1) % 256, v);
      chk("R4", int'(s_inc[0]), (v & 1) ^ 1, v);
      chk("R4", int'(c_inc), (v == 255) ? 1 : 0, v);
      chk("R5", int'(s_dec), (v + 255) % 256, v);
      chk("R5", int'(c_dec), (v != 0) ? 1 : 0, v);
      chk("R6", int'(s_zero), v, v);
      chk("R6", int'(c_zero), 0, v);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule